// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block sits in the decode stage of a five-stage in-order pipeline. It decides control transfers there and gives the fetch unit the address of the next instruction in program order. A dedicated adder forms the PC-relative target while the register file is being read, so a branch never needs the ALU. A full-width compare on the two register operands settles conditional branches in the same cycle.

By the time a branch is resolved, the instruction behind it has already been fetched. A two-bit policy input decides what happens to that instruction:

- Flush on taken: the instruction behind the branch runs only when the branch falls through.
- Likely: it runs only when the branch is taken.
- Delay slot: it always runs, and the redirect takes effect after it.

An instruction that runs in a slot behind a taken or delayed transfer has to restart from the branch if it faults. For that reason the block holds the branch address for one cycle and reports the restart address for whatever instruction is in decode.

Top module: `branch_resolve_unit`

## Requirements
- R1: When `dec_valid` is 0, or `br_kind` is 0 (no transfer) or 7 (reserved), `taken` is 0, `annul_next` is 0 and `next_pc` equals `pc + 4`.
- R2: For `br_kind` 1 (relative jump), and for a conditional kind whose condition holds, `next_pc` equals `pc + 4 + (sign-extended offset << 2)`, wrapping modulo 2^32.
- R3: For `br_kind` 2 (register jump), the transfer is always taken and `next_pc` equals `rs_val` unchanged. The offset has no effect.
- R4: The conditional kinds are 3 (rs == rt), 4 (rs != rt), 5 (rs < 0, signed) and 6 (rs >= 0, signed). Kinds 5 and 6 ignore `rt_val`. `taken` is 1 exactly when the condition holds.
- R5: Under `policy` 0 (flush on taken), `annul_next` equals `taken` for a valid transfer.
- R6: Under `policy` 1 (likely), `annul_next` is 1 for a valid conditional kind whose condition fails, and 0 whenever the transfer is taken.
- R7: Under `policy` 2 (delay slot), `annul_next` is always 0.
- R8: `policy` 3 behaves exactly like `policy` 0.
- R9: Consider the cycle after a valid transfer. If `policy` was 2, or `policy` was 1 and the transfer was taken, then `slot_in_delay` is 1 and `restart_pc` equals that transfer's `pc`. In every other cycle `slot_in_delay` is 0 and `restart_pc` equals the current `pc`.
- R10: After reset, `slot_in_delay` is 0 and `restart_pc` equals `pc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode holds a valid instruction |
| br_kind | input | 3 | Transfer kind (0 none, 1 relative jump, 2 register jump, 3 eq, 4 ne, 5 ltz, 6 gez, 7 none) |
| policy | input | 2 | Treatment of the instruction behind a transfer (0 flush, 1 likely, 2 delay slot, 3 as 0) |
| pc | input | XLEN | Address of the instruction in decode |
| offset | input | OFF_W | Word offset of a relative transfer |
| rs_val | input | XLEN | First register operand |
| rt_val | input | XLEN | Second register operand |
| next_pc | output | XLEN | Next address in program order after the decode instruction |
| taken | output | 1 | The transfer redirects fetch |
| annul_next | output | 1 | Turn the already fetched next instruction into a NOP |
| slot_in_delay | output | 1 | The decode instruction executes in a slot behind a transfer |
| restart_pc | output | XLEN | Restart address if the decode instruction faults |

## Verification
The assertions check the following on every cycle:
- the idle case, where there is no transfer;
- the register-jump target;
- the annul rules of each policy, insofar as they depend only on the policy and `taken`;
- the one-cycle hand-off of the branch address into `restart_pc`.

The arithmetic of the relative target, the signed sign-bit conditions, address wrap-around and the likely policy's annul on a failed condition can only be shown by the bench. The bench covers these by sweeping every kind, policy, operand class and offset sign, and it compares the results against values it computes itself.

// File: rtl/bru_pkg.sv
package bru_pkg;

   typedef enum logic [2:0] {
      BK_NONE = 3'd0,
      BK_JREL = 3'd1,
      BK_JREG = 3'd2,
      BK_EQ   = 3'd3,
      BK_NE   = 3'd4,
      BK_LTZ  = 3'd5,
      BK_GEZ  = 3'd6,
      BK_RSVD = 3'd7
   } br_kind_e;

   typedef enum logic [1:0] {
      SP_FLUSH  = 2'd0,
      SP_LIKELY = 2'd1,
      SP_DELAY  = 2'd2,
      SP_ALT    = 2'd3
   } slot_policy_e;

   function automatic logic kind_is_cond(br_kind_e k);
      return (k == BK_EQ) || (k == BK_NE) || (k == BK_LTZ) || (k == BK_GEZ);
   endfunction

   function automatic logic kind_is_xfer(br_kind_e k);
      return (k == BK_JREL) || (k == BK_JREG) || kind_is_cond(k);
   endfunction

endpackage

// File: rtl/bru_target_adder.sv
module bru_target_adder #(
   parameter int XLEN       = 32,
   parameter int OFF_W      = 16,
   parameter int INSN_BYTES = 4
) (
   input  logic [XLEN-1:0]  pc,
   input  logic [OFF_W-1:0] offset,
   output logic [XLEN-1:0]  seq_pc,
   output logic [XLEN-1:0]  rel_target
);
   localparam int SH   = $clog2(INSN_BYTES);
   localparam int WIDE = OFF_W + SH + 1;

   logic [XLEN-1:0] disp;

   generate
      if (WIDE > XLEN) begin : g_trunc
         logic [WIDE-1:0] wide;
         assign wide = {offset[OFF_W-1], offset} << SH;
         assign disp = wide[XLEN-1:0];
      end else begin : g_sext
         assign disp = {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset} << SH;
      end
   endgenerate

   assign seq_pc     = pc + XLEN'(INSN_BYTES);
   assign rel_target = seq_pc + disp;
endmodule

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
   import bru_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  br_kind_e        kind,
   input  logic [XLEN-1:0] rs_val,
   input  logic [XLEN-1:0] rt_val,
   output logic            cond_true
);
   logic same;
   logic neg;

   assign same = (rs_val == rt_val);
   assign neg  = rs_val[XLEN-1];

   always_comb begin
      unique case (kind)
         BK_EQ:   cond_true = same;
         BK_NE:   cond_true = !same;
         BK_LTZ:  cond_true = neg;
         BK_GEZ:  cond_true = !neg;
         default: cond_true = 1'b0;
      endcase
   end
endmodule

// File: rtl/bru_slot_policy.sv
module bru_slot_policy
   import bru_pkg::*;
(
   input  logic         xfer,
   input  logic         is_cond,
   input  logic         taken,
   input  slot_policy_e policy,
   output logic         annul,
   output logic         slot_follows
);
   always_comb begin
      annul        = 1'b0;
      slot_follows = 1'b0;
      if (xfer) begin
         unique case (policy)
            SP_LIKELY: begin
               annul        = is_cond && !taken;
               slot_follows = taken;
            end
            SP_DELAY: begin
               slot_follows = 1'b1;
            end
            default: begin
               annul = taken;
            end
         endcase
      end
   end
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
   import bru_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int OFF_W      = 16,
   parameter int INSN_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_valid,
   input  logic [2:0]       br_kind,
   input  logic [1:0]       policy,
   input  logic [XLEN-1:0]  pc,
   input  logic [OFF_W-1:0] offset,
   input  logic [XLEN-1:0]  rs_val,
   input  logic [XLEN-1:0]  rt_val,
   output logic [XLEN-1:0]  next_pc,
   output logic             taken,
   output logic             annul_next,
   output logic             slot_in_delay,
   output logic [XLEN-1:0]  restart_pc
);
   generate
      if (XLEN < 8) begin : g_bad_xlen
         $error("branch_resolve_unit: XLEN must be at least 8");
      end
      if (OFF_W < 1 || OFF_W > XLEN) begin : g_bad_off
         $error("branch_resolve_unit: OFF_W must lie in 1..XLEN");
      end
      if (INSN_BYTES < 1 || (INSN_BYTES & (INSN_BYTES - 1)) != 0) begin : g_bad_ib
         $error("branch_resolve_unit: INSN_BYTES must be a power of two");
      end
   endgenerate

   br_kind_e        kind;
   slot_policy_e    pol;
   logic            is_cond;
   logic            xfer;
   logic            cond_true;
   logic            slot_follows;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] rel_target;
   logic            slot_q;
   logic [XLEN-1:0] branch_pc_q;

   assign kind    = br_kind_e'(br_kind);
   assign pol     = slot_policy_e'(policy);
   assign is_cond = dec_valid && kind_is_cond(kind);
   assign xfer    = dec_valid && kind_is_xfer(kind);

   bru_target_adder #(
      .XLEN(XLEN), .OFF_W(OFF_W), .INSN_BYTES(INSN_BYTES)
   ) u_adder (
      .pc(pc), .offset(offset), .seq_pc(seq_pc), .rel_target(rel_target)
   );

   bru_cond_eval #(.XLEN(XLEN)) u_cond (
      .kind(kind), .rs_val(rs_val), .rt_val(rt_val), .cond_true(cond_true)
   );

   assign taken = xfer && (!is_cond || cond_true);

   always_comb begin
      if (!taken)
         next_pc = seq_pc;
      else if (kind == BK_JREG)
         next_pc = rs_val;
      else
         next_pc = rel_target;
   end

   bru_slot_policy u_policy (
      .xfer(xfer), .is_cond(is_cond), .taken(taken), .policy(pol),
      .annul(annul_next), .slot_follows(slot_follows)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q      <= 1'b0;
         branch_pc_q <= '0;
      end else begin
         slot_q <= slot_follows;
         if (slot_follows)
            branch_pc_q <= pc;
      end
   end

   assign slot_in_delay = slot_q;
   assign restart_pc    = slot_q ? branch_pc_q : pc;
endmodule

// File: rtl/bru_checks.sv
module bru_checks #(
   parameter int XLEN       = 32,
   parameter int INSN_BYTES = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            dec_valid,
   input logic [2:0]      br_kind,
   input logic [1:0]      policy,
   input logic [XLEN-1:0] pc,
   input logic [XLEN-1:0] rs_val,
   input logic [XLEN-1:0] next_pc,
   input logic            taken,
   input logic            annul_next,
   input logic            slot_in_delay,
   input logic [XLEN-1:0] restart_pc
);
   logic real_xfer;
   assign real_xfer = dec_valid && (br_kind != 3'd0) && (br_kind != 3'd7);

   a_r1_idle_sequential: assert property (@(posedge clk) disable iff (!rst_n)
      !real_xfer |-> (!taken && !annul_next && next_pc == pc + XLEN'(INSN_BYTES)));

   a_r3_register_jump: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && br_kind == 3'd2) |-> (taken && next_pc == rs_val));

   a_r5_flush_on_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (policy == 2'd0 && real_xfer) |-> (annul_next == taken));

   a_r8_alt_as_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (policy == 2'd3 && real_xfer) |-> (annul_next == taken));

   a_r6_likely_keeps_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (policy == 2'd1 && taken) |-> !annul_next);

   a_r7_delay_never_annuls: assert property (@(posedge clk) disable iff (!rst_n)
      (policy == 2'd2) |-> !annul_next);

   a_r9_delay_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (real_xfer && policy == 2'd2) |=> (slot_in_delay && restart_pc == $past(pc)));

   a_r9_plain_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_in_delay |-> (restart_pc == pc));
endmodule

bind branch_resolve_unit bru_checks #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_bru_checks (
   .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .br_kind(br_kind),
   .policy(policy), .pc(pc), .rs_val(rs_val), .next_pc(next_pc),
   .taken(taken), .annul_next(annul_next), .slot_in_delay(slot_in_delay),
   .restart_pc(restart_pc)
);

// File: tb/branch_resolve_unit_test.sv
module branch_resolve_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dec_valid = 1'b0;
   logic [2:0]  br_kind = 3'd0;
   logic [1:0]  policy = 2'd0;
   logic [31:0] pc = 32'h0000_1000;
   logic [15:0] offset = 16'd0;
   logic [31:0] rs_val = 32'd0;
   logic [31:0] rt_val = 32'd0;
   logic [31:0] next_pc;
   logic        taken;
   logic        annul_next;
   logic        slot_in_delay;
   logic [31:0] restart_pc;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   branch_resolve_unit uut (
      .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .br_kind(br_kind),
      .policy(policy), .pc(pc), .offset(offset), .rs_val(rs_val), .rt_val(rt_val),
      .next_pc(next_pc), .taken(taken), .annul_next(annul_next),
      .slot_in_delay(slot_in_delay), .restart_pc(restart_pc)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] op_rs(int i);
      case (i)
         0: return 32'd5;
         1: return 32'd5;
         2: return 32'hFFFF_FFF0;
         3: return 32'd0;
         default: return 32'h7FFF_FFFF;
      endcase
   endfunction

   function automatic logic [31:0] op_rt(int i);
      case (i)
         0: return 32'd5;
         1: return 32'd6;
         2: return 32'd0;
         3: return 32'd0;
         default: return 32'd1;
      endcase
   endfunction

   function automatic logic [15:0] off_of(int i);
      case (i)
         0: return 16'h0010;
         1: return 16'hFFFC;
         default: return 16'h8000;
      endcase
   endfunction

   function automatic logic [31:0] pc_of(int i);
      case (i % 3)
         0: return 32'h0000_1000 + 32'(i * 4);
         1: return 32'hFFFF_FFF8;
         default: return 32'h0000_0004;
      endcase
   endfunction

   bit          prev_slot = 1'b0;
   logic [31:0] prev_pc   = 32'd0;

   task automatic vec(input bit v, input int pol, input int k, input int op,
                      input int oi, input int idx);
      bit          e_cond, e_taken, e_annul, e_slot, is_c, is_x;
      logic [31:0] e_next, e_rst, seq;
      @(negedge clk);
      dec_valid = v;
      policy    = 2'(pol);
      br_kind   = 3'(k);
      rs_val    = op_rs(op);
      rt_val    = op_rt(op);
      offset    = off_of(oi);
      pc        = pc_of(idx);
      #1;
      // R9: slot state from the previous vector
      e_rst = prev_slot ? prev_pc : pc;
      check(slot_in_delay == prev_slot, "R9 slot_in_delay", 32'(slot_in_delay), 32'(prev_slot));
      check(restart_pc == e_rst, "R9 restart_pc", restart_pc, e_rst);

      is_c = v && (k >= 3 && k <= 6);
      is_x = v && (k >= 1 && k <= 6);
      case (k)
         3: e_cond = (rs_val == rt_val);
         4: e_cond = (rs_val != rt_val);
         5: e_cond = ($signed(rs_val) < 0);
         6: e_cond = ($signed(rs_val) >= 0);
         default: e_cond = 1'b0;
      endcase
      e_taken = is_x && (!is_c || e_cond);
      seq = pc + 32'd4;
      if (!e_taken) e_next = seq;
      else if (k == 2) e_next = rs_val;
      else e_next = seq + (32'($signed(offset)) * 32'd4);

      case (pol)
         1: begin e_annul = is_c && !e_taken; e_slot = e_taken; end
         2: begin e_annul = 1'b0; e_slot = is_x; end
         default: begin e_annul = e_taken; e_slot = 1'b0; end
      endcase

      check(taken == e_taken, "R4 taken", 32'(taken), 32'(e_taken));
      check(next_pc == e_next, !e_taken ? "R1 next_pc" : (k == 2 ? "R3 next_pc" : "R2 next_pc"),
            next_pc, e_next);
      case (pol)
         0: check(annul_next == e_annul, "R5 annul_next", 32'(annul_next), 32'(e_annul));
         1: check(annul_next == e_annul, "R6 annul_next", 32'(annul_next), 32'(e_annul));
         2: check(annul_next == e_annul, "R7 annul_next", 32'(annul_next), 32'(e_annul));
         default: check(annul_next == e_annul, "R8 annul_next", 32'(annul_next), 32'(e_annul));
      endcase
      prev_slot = e_slot;
      prev_pc   = pc;
   endtask

   initial begin
      int idx = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10: reset state
      check(slot_in_delay == 1'b0, "R10 slot_in_delay", 32'(slot_in_delay), 32'd0);
      check(restart_pc == pc, "R10 restart_pc", restart_pc, pc);
      for (int v = 0; v < 2; v++)
         for (int pol = 0; pol < 4; pol++)
            for (int k = 0; k < 8; k++)
               for (int op = 0; op < 5; op++)
                  for (int oi = 0; oi < 3; oi++) begin
                     vec(v[0], pol, k, op, oi, idx);
                     idx++;
                  end
      vec(1'b0, 0, 0, 0, 0, idx);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule